// File: doc/BRIEF.md
# Shared-Vector Interrupt Router with Derived Pending

This block collects level-sensitive interrupt inputs and routes them onto a small set of numbered output lines. Each route is set by a vector register holding a destination server, a priority and a source number. A vector's source number picks which output line it drives. The first two inputs are merged into vector 0. Every other input has a vector of its own. With the default of six vectors there are seven inputs and eight output lines.

Each input level is captured into a status bit. Software can read the status bits through the register port. A vector whose effective level is high drives its selected output line high. The line follows the level and is not gated by the priority. Each vector also exposes a pending flag. This flag is not stored: it is computed every cycle as "effective level is high and the priority is not all ones". An all-ones priority is the mask value. The block also reports each vector's server with the two low link-pointer bits removed, together with its priority.

Software updates a vector through a one-cycle write strobe. A write that names a source number outside the range of vectors is refused: the register keeps its old contents and an error pulse is raised.

Top module: `ivr_router`

## Requirements
- R1: After reset every vector reads back with server 0, priority 0xFF, source number equal to its own index and pending 0. All output lines, `wr_err` and all status bits are 0.
- R2: A vector read (index 0 to NUM_VEC-1) returns the following fields, with every other bit zero:
  - server in bits 55:40
  - priority in bits 39:32
  - source number in bits 31:29
  - pending in bit 24

  A write updates only the server, priority and source fields. All other written bits are dropped.
- R3: Status bits follow each input with one cycle of delay.
  - Index NUM_VEC is the pair register. It shows input 0 at bit 47 and input 1 at bit 46.
  - Index NUM_VEC+1 is the solo register. It shows input i (for i ≥ 2) at bit 38-i, so inputs 2 to 6 land on bits 36 down to 32.
  - All other bits of these two registers read 0.
- R4: Output line k is high exactly when at least one vector with source number k has its effective level high. The priority, including the mask value, does not affect the line.
- R5: Vector 0's effective level is input 0 OR input 1. Its line stays high while either input is still set. Vector v ≥ 1 takes input v+1.
- R6: A vector's pending bit reads 1 only when its effective level is 1 and its priority is not 0xFF. Writing 0xFF clears the bit at once. Writing another priority keeps the bit set while the input stays active.
- R7: `srv_eff` carries, per vector v in slice v, the server field shifted right by 2. `vec_pri` carries the priority.
- R8: A vector write whose source field is NUM_VEC or above leaves the vector unchanged. `wr_err` is 1 in the following cycle only.
- R9: A read of an index above NUM_VEC+1 returns all ones. Writes to the pair, solo or unmapped indices change nothing.
- R10: When several vectors share a source number, their effective levels are ORed onto that one line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_VEC+1 | Interrupt input levels |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | ADDR_W | Register index for writes |
| wr_data | input | 64 | Write data |
| rd_idx | input | ADDR_W | Register index for reads (combinational) |
| rd_data | output | 64 | Read data |
| irq_out | output | NUM_OUT | Output lines indexed by source number |
| wr_err | output | 1 | One-cycle pulse after a refused vector write |
| srv_eff | output | NUM_VEC*14 | Per-vector server with link bits dropped |
| vec_pri | output | NUM_VEC*8 | Per-vector priority |

## Verification
The assertions check the following on every cycle:
- A masked priority never shows as pending.
- Reserved vector bits read zero.
- Pair and solo status bits equal the inputs of the previous cycle.
- Unmapped reads return all ones.
- `wr_err` pulses after a refused write and at no other time.

Only the bench scenarios can show the rest. One part is the routing of levels onto lines across all 128 input patterns under two source maps, one of them with shared lines. The other parts are the pair-hold sequence on vector 0, and whether pending survives a rewrite of a non-mask priority.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
   localparam int DW        = 64;
   localparam int SRV_W     = 16;
   localparam int PRI_W     = 8;
   localparam int SRC_W     = 3;
   localparam int LINK_W    = 2;
   localparam int SRV_LSB   = 40;
   localparam int PRI_LSB   = 32;
   localparam int SRC_LSB   = 29;
   localparam int PEND_POS  = 24;
   localparam int PAIR_POS  = 47;   // input 0; input 1 one below
   localparam int SOLO_TOP  = 36;   // input 2; later inputs descend

   typedef struct packed {
      logic [SRV_W-1:0] srv;
      logic [PRI_W-1:0] pri;
      logic [SRC_W-1:0] src;
   } vec_t;
endpackage

// File: rtl/ivr_vec_reg.sv
module ivr_vec_reg
   import ivr_pkg::*;
#(
   parameter int IDX     = 0,
   parameter int NUM_VEC = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_sel,
   input  logic [DW-1:0] wr_data,
   output vec_t          vec_q,
   output logic          reject
);
   logic [SRC_W-1:0] new_src;
   assign new_src = wr_data[SRC_LSB +: SRC_W];
   assign reject  = wr_sel && (32'(new_src) >= NUM_VEC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q.srv <= '0;
         vec_q.pri <= '1;
         vec_q.src <= SRC_W'(IDX);
      end else if (wr_sel && !reject) begin
         vec_q.srv <= wr_data[SRV_LSB +: SRV_W];
         vec_q.pri <= wr_data[PRI_LSB +: PRI_W];
         vec_q.src <= new_src;
      end
   end
endmodule

// File: rtl/ivr_status.sv
module ivr_status #(
   parameter int NUM_VEC = 6,
   localparam int NUM_IN = NUM_VEC + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] irq_in,
   output logic [NUM_IN-1:0] lvl_q,
   output logic [NUM_VEC-1:0] vec_lvl
);
   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= irq_in;
   end

   // vector 0 merges the first two inputs
   assign vec_lvl[0] = lvl_q[0] | lvl_q[1];

   for (genvar v = 1; v < NUM_VEC; v++) begin : g_solo
      assign vec_lvl[v] = lvl_q[v+1];
   end
endmodule

// File: rtl/ivr_route.sv
module ivr_route
   import ivr_pkg::*;
#(
   parameter int NUM_VEC = 6,
   parameter int NUM_OUT = 8
) (
   input  logic [NUM_VEC-1:0]            vec_lvl,
   input  logic [NUM_VEC-1:0][SRC_W-1:0] vec_src,
   output logic [NUM_OUT-1:0]            line
);
   for (genvar k = 0; k < NUM_OUT; k++) begin : g_line
      logic hit;
      always_comb begin
         hit = 1'b0;
         for (int v = 0; v < NUM_VEC; v++)
            if (vec_lvl[v] && (vec_src[v] == SRC_W'(k))) hit = 1'b1;
      end
      assign line[k] = hit;
   end
endmodule

// File: rtl/ivr_router.sv
module ivr_router
   import ivr_pkg::*;
#(
   parameter int NUM_VEC = 6,
   parameter int NUM_OUT = 8,
   parameter int ADDR_W  = 4,
   localparam int NUM_IN    = NUM_VEC + 1,
   localparam int SRV_EFF_W = SRV_W - LINK_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_IN-1:0]             irq_in,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_idx,
   input  logic [DW-1:0]                 wr_data,
   input  logic [ADDR_W-1:0]             rd_idx,
   output logic [DW-1:0]                 rd_data,
   output logic [NUM_OUT-1:0]            irq_out,
   output logic                          wr_err,
   output logic [NUM_VEC*SRV_EFF_W-1:0]  srv_eff,
   output logic [NUM_VEC*PRI_W-1:0]      vec_pri
);
   localparam int PAIR_IDX = NUM_VEC;
   localparam int SOLO_IDX = NUM_VEC + 1;

   if (NUM_VEC < 1 || NUM_VEC > (1 << SRC_W)) begin : g_bad_vec
      $error("NUM_VEC must lie in 1..2**SRC_W");
   end
   if (NUM_OUT < NUM_VEC || NUM_OUT > (1 << SRC_W)) begin : g_bad_out
      $error("NUM_OUT must lie in NUM_VEC..2**SRC_W");
   end
   if (SOLO_IDX >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register set");
   end

   vec_t                          vec_q  [NUM_VEC];
   logic [NUM_VEC-1:0]            wr_sel;
   logic [NUM_VEC-1:0]            reject;
   logic [NUM_VEC-1:0][SRC_W-1:0] vec_src;
   logic [NUM_VEC-1:0]            vec_lvl;
   logic [NUM_VEC-1:0]            pend;
   logic [NUM_IN-1:0]             lvl_q;

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      assign wr_sel[v] = wr_en && (wr_idx == ADDR_W'(v));

      ivr_vec_reg #(.IDX(v), .NUM_VEC(NUM_VEC)) u_reg (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_sel (wr_sel[v]),
         .wr_data(wr_data),
         .vec_q  (vec_q[v]),
         .reject (reject[v])
      );

      assign vec_src[v] = vec_q[v].src;
      assign pend[v]    = vec_lvl[v] && (vec_q[v].pri != '1);
      assign srv_eff[v*SRV_EFF_W +: SRV_EFF_W] = vec_q[v].srv[SRV_W-1:LINK_W];
      assign vec_pri[v*PRI_W +: PRI_W]         = vec_q[v].pri;
   end

   ivr_status #(.NUM_VEC(NUM_VEC)) u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq_in (irq_in),
      .lvl_q  (lvl_q),
      .vec_lvl(vec_lvl)
   );

   ivr_route #(.NUM_VEC(NUM_VEC), .NUM_OUT(NUM_OUT)) u_route (
      .vec_lvl(vec_lvl),
      .vec_src(vec_src),
      .line   (irq_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) wr_err <= 1'b0;
      else        wr_err <= |reject;
   end

   always_comb begin
      rd_data = '1;
      if (32'(rd_idx) < NUM_VEC) begin
         rd_data = '0;
         for (int v = 0; v < NUM_VEC; v++) begin
            if (rd_idx == ADDR_W'(v)) begin
               rd_data[SRV_LSB +: SRV_W] = vec_q[v].srv;
               rd_data[PRI_LSB +: PRI_W] = vec_q[v].pri;
               rd_data[SRC_LSB +: SRC_W] = vec_q[v].src;
               rd_data[PEND_POS]         = pend[v];
            end
         end
      end else if (32'(rd_idx) == PAIR_IDX) begin
         rd_data             = '0;
         rd_data[PAIR_POS]   = lvl_q[0];
         rd_data[PAIR_POS-1] = lvl_q[1];
      end else if (32'(rd_idx) == SOLO_IDX) begin
         rd_data = '0;
         for (int i = 2; i < NUM_IN; i++)
            rd_data[SOLO_TOP-(i-2)] = lvl_q[i];
      end
   end
endmodule

// File: rtl/ivr_router_chk.sv
module ivr_router_chk
   import ivr_pkg::*;
#(
   parameter int NUM_VEC = 6,
   parameter int NUM_OUT = 8,
   parameter int ADDR_W  = 4,
   localparam int NUM_IN = NUM_VEC + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_IN-1:0] irq_in,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_idx,
   input logic [DW-1:0]     wr_data,
   input logic [ADDR_W-1:0] rd_idx,
   input logic [DW-1:0]     rd_data,
   input logic [NUM_OUT-1:0] irq_out,
   input logic              wr_err
);
   localparam logic [DW-1:0] FIELD_MASK =
      (DW'({{SRV_W{1'b1}}, {PRI_W{1'b1}}, {SRC_W{1'b1}}}) << SRC_LSB) |
      (DW'(1) << PEND_POS);

   logic warm;
   always_ff @(posedge clk) begin
      if (!rst_n) warm <= 1'b0;
      else        warm <= 1'b1;
   end

   logic bad_wr;
   assign bad_wr = wr_en && (32'(wr_idx) < NUM_VEC) &&
                   (32'(wr_data[SRC_LSB +: SRC_W]) >= NUM_VEC);

   a_r8_err_after_reject: assert property (@(posedge clk) disable iff (!rst_n)
      bad_wr |=> wr_err);

   a_r8_err_only_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
      !bad_wr |=> !wr_err);

   a_r6_masked_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
      ((32'(rd_idx) < NUM_VEC) && (rd_data[PRI_LSB +: PRI_W] == '1)) |-> !rd_data[PEND_POS]);

   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(rd_idx) < NUM_VEC) |-> ((rd_data & ~FIELD_MASK) == '0));

   a_r3_pair_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && (32'(rd_idx) == NUM_VEC)) |->
         (rd_data[PAIR_POS] == $past(irq_in[0]) && rd_data[PAIR_POS-1] == $past(irq_in[1])));

   a_r3_solo_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && (32'(rd_idx) == NUM_VEC + 1)) |-> (rd_data[SOLO_TOP] == $past(irq_in[2])));

   a_r9_unmapped_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(rd_idx) > NUM_VEC + 1) |-> (rd_data == '1));
endmodule

bind ivr_router ivr_router_chk #(.NUM_VEC(NUM_VEC), .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_idx(wr_idx),
   .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .irq_out(irq_out),
   .wr_err(wr_err)
);

// File: tb/tb_ivr_router.sv
module tb_ivr_router;
   localparam int NV = 6;
   localparam int NO = 8;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NV:0]   irq_in = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_idx = '0;
   logic [63:0]   wr_data = '0;
   logic [AW-1:0] rd_idx = '0;
   logic [63:0]   rd_data;
   logic [NO-1:0] irq_out;
   logic          wr_err;
   logic [NV*14-1:0] srv_eff;
   logic [NV*8-1:0]  vec_pri;

   always #10 clk = ~clk;

   ivr_router #(.NUM_VEC(NV), .NUM_OUT(NO), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .irq_out(irq_out),
      .wr_err(wr_err), .srv_eff(srv_eff), .vec_pri(vec_pri)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   logic [15:0] m_srv [NV];
   logic [7:0]  m_pri [NV];
   logic [2:0]  m_src [NV];

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(int idx, output logic [63:0] d);
      rd_idx = AW'(idx);
      #1;
      d = rd_data;
   endtask

   task automatic wr(int idx, logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = AW'(idx); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (idx < NV && d[31:29] < NV) begin
         m_srv[idx] = d[55:40]; m_pri[idx] = d[39:32]; m_src[idx] = d[31:29];
      end
   endtask

   task automatic set_in(logic [NV:0] p);
      @(negedge clk);
      irq_in = p;
      @(negedge clk);
   endtask

   function automatic logic vlvl(logic [NV:0] p, int v);
      return (v == 0) ? (p[0] | p[1]) : p[v+1];
   endfunction

   function automatic logic [63:0] vexp(int v, logic pend);
      return {8'h00, m_srv[v], m_pri[v], m_src[v], 4'h0, pend, 24'h0};
   endfunction

   function automatic logic [63:0] mkvec(logic [15:0] s, logic [7:0] p, logic [2:0] src);
      return {8'hA5, s, p, src, 4'hF, 1'b1, 24'hFFFFFF};
   endfunction

   task automatic check_pattern(string req, logic [NV:0] p);
      logic [NO-1:0] eo;
      logic [63:0] d, e;
      eo = '0;
      for (int v = 0; v < NV; v++) if (vlvl(p, v)) eo[m_src[v]] = 1'b1;
      chk({req, " lines"}, 64'(irq_out), 64'(eo));
      rd(NV, d);
      e = '0; e[47] = p[0]; e[46] = p[1];
      chk("R3 pair status", d, e);
      rd(NV+1, d);
      e = '0;
      for (int i = 2; i <= NV; i++) e[38-i] = p[i];
      chk("R3 solo status", d, e);
      for (int v = 0; v < NV; v++) begin
         rd(v, d);
         chk("R6 pending", d, vexp(v, vlvl(p, v) && m_pri[v] != 8'hFF));
      end
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [63:0] d;
      for (int v = 0; v < NV; v++) begin
         m_srv[v] = '0; m_pri[v] = 8'hFF; m_src[v] = 3'(v);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int v = 0; v < NV; v++) begin
         rd(v, d);
         chk("R1 reset vector", d, vexp(v, 1'b0));
      end
      chk("R1 reset lines", 64'(irq_out), 64'h0);
      chk("R1 reset err", 64'(wr_err), 64'h0);
      rd(NV, d);   chk("R1 reset pair", d, 64'h0);
      rd(NV+1, d); chk("R1 reset solo", d, 64'h0);

      // R2/R7: writes with junk bits everywhere else
      for (int v = 0; v < NV; v++)
         wr(v, mkvec(16'h1230 + 16'(v * 7), 8'(v * 16 + 1), 3'(NV - 1 - v)));
      wr(3, mkvec(16'hBEEF, 8'hFF, 3'd3));
      for (int v = 0; v < NV; v++) begin
         rd(v, d);
         chk("R2 readback", d, vexp(v, 1'b0));
         chk("R7 server shift", 64'(srv_eff[v*14 +: 14]), 64'(m_srv[v] >> 2));
         chk("R7 priority", 64'(vec_pri[v*8 +: 8]), 64'(m_pri[v]));
      end

      // R4/R5/R6 sweep, one-to-one source map (vector 3 masked)
      for (int p = 0; p < (1 << (NV + 1)); p++) begin
         set_in((NV+1)'(p));
         check_pattern("R4 R5 sweep", (NV+1)'(p));
      end

      // R5 pair hold sequence
      set_in(7'b0000001);
      chk("R5 in0 only", 64'(irq_out[m_src[0]]), 64'h1);
      set_in(7'b0000011);
      set_in(7'b0000010);
      chk("R5 held by in1", 64'(irq_out[m_src[0]]), 64'h1);
      set_in(7'b0000000);
      chk("R5 both low", 64'(irq_out[m_src[0]]), 64'h0);

      // R6 pending across rewrites
      set_in(7'b0000100);   // vector 1 active
      wr(1, mkvec(16'h0040, 8'h10, m_src[1]));
      rd(1, d); chk("R6 pending kept", d, vexp(1, 1'b1));
      wr(1, mkvec(16'h0040, 8'hFF, m_src[1]));
      rd(1, d); chk("R6 mask clears", d, vexp(1, 1'b0));
      chk("R4 masked still drives", 64'(irq_out[m_src[1]]), 64'h1);
      wr(1, mkvec(16'h0040, 8'h20, m_src[1]));
      rd(1, d); chk("R6 unmask restores", d, vexp(1, 1'b1));
      set_in('0);

      // R8 refused source numbers
      for (int s = NV; s < 8; s++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_idx = 4'd2; wr_data = mkvec(16'hFFFF, 8'h00, 3'(s));
         @(negedge clk);
         wr_en = 1'b0;
         chk("R8 err pulse", 64'(wr_err), 64'h1);
         rd(2, d); chk("R8 vector kept", d, vexp(2, 1'b0));
         @(negedge clk);
         chk("R8 err one cycle", 64'(wr_err), 64'h0);
      end

      // R9 unmapped reads and ignored writes
      for (int i = NV + 2; i < 16; i++) begin
         rd(i, d); chk("R9 unmapped ones", d, 64'hFFFF_FFFF_FFFF_FFFF);
      end
      wr(NV, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(NV+1, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(9, 64'h0);
      rd(NV, d);   chk("R9 pair unwritable", d, 64'h0);
      rd(NV+1, d); chk("R9 solo unwritable", d, 64'h0);
      for (int v = 0; v < NV; v++) begin
         rd(v, d); chk("R9 vectors intact", d, vexp(v, 1'b0));
      end

      // R10 shared lines: vector v uses source v%3
      for (int v = 0; v < NV; v++) wr(v, mkvec(16'(v * 4 + 3), 8'(v), 3'(v % 3)));
      for (int p = 0; p < (1 << (NV + 1)); p++) begin
         set_in((NV+1)'(p));
         check_pattern("R10 shared", (NV+1)'(p));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule